// File: doc/BRIEF.md
# Fractional Multiply Product Unit

This block keeps a wide product register that a 16x16 multiplier feeds. On each start strobe it applies one command: load the register with a new product, add a new product to the register, subtract a new product from it, or clear it to a fixed set of nonzero sub-word patterns. A mode input chooses whether the raw product is doubled before use. Doubling aligns the result for fractional (Q15) arithmetic. When the mode bit is set, the product is used as is.

The register is held as four 16-bit sub-words. Its numeric value is formed from all four, with two of them overlapping at the same weight. For that reason, the cleared register reads as zero even though its sub-words are not zero. The unit drives both the composed 40-bit value and the raw sub-words. Each result appears one clock after its strobe, together with a one-cycle valid pulse. Operand selection, accumulators and status flags belong to the surrounding datapath.

Top module: `frac_prod_unit`

## Requirements
- R1: With cmd_i = 2'b00 (load) and shift_off_i = 0, the register value becomes the signed product of op_a_i and op_b_i shifted left by one, sign-extended to 40 bits.
- R2: With shift_off_i = 1, the product is used without the left shift, for every multiply command.
- R3: With cmd_i = 2'b01 (add), the new value is the old value plus the new product, modulo 2^40.
- R4: With cmd_i = 2'b10 (subtract), the new value is the old value minus the new product, modulo 2^40.
- R5: With cmd_i = 2'b11 (clear), the sub-words 0..3 become 0x0000, 0xFFF0, 0x00FF and 0x0010, and the operands and mode are ignored.
- R6: prod_words_o holds sub-word k in bits [16k+15:16k]. prod_o equals w0 + (w1 + w3)*2^16 + w2*2^32 modulo 2^40, so a cleared register reads as 0.
- R7: After any multiply command, w0 and w1 hold bits 15:0 and 31:16 of the value, w2 holds bits 39:32 sign-extended to 16 bits, and w3 is 0.
- R8: valid_o is high in exactly the cycle after a cycle with start_i high, and results update at that same edge.
- R9: Without start_i, the register holds, whatever the other inputs do.
- R10: Reset (rst_ni low) loads the clear pattern and forces valid_o low.
- R11: With the default UNSIGNED_MUL = 0, the operands are two's complement: 0x8000 x 0x8000 doubled gives 0x0080000000, and 0xFFFF x 0x0001 doubled gives 0xFFFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| cmd_i | input | 2 | 00 load, 01 add, 10 subtract, 11 clear |
| shift_off_i | input | 1 | 1: use the product unshifted; 0: double it |
| op_a_i | input | 16 | First operand |
| op_b_i | input | 16 | Second operand |
| valid_o | output | 1 | Result pulse, one cycle after start |
| prod_o | output | 40 | Composed register value |
| prod_words_o | output | 64 | Raw sub-words w3..w0 |

## Verification
The directed cases cover several situations:
- The most negative operand squared, which shows whether the operands are signed and whether the doubling is done at full width.
- Minus one times one, which shows whether the high sub-word is sign-extended.
- An add issued straight after a clear, which shows whether the overlapping sub-words are composed correctly.
- Each command repeated with and without doubling, which tells the shift apart from the command selection.

Random mixes of all four commands on random operands then check that the running sum wraps at 40 bits. Idle cycles with random garbage on the inputs show that nothing moves without a strobe.

// File: rtl/frac_prod_pkg.sv
package frac_prod_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned N_WORDS = 4;
  localparam int unsigned WORDS_W = WORD_W * N_WORDS;

  typedef enum logic [1:0] {
    CMD_LOAD  = 2'b00,
    CMD_ADD   = 2'b01,
    CMD_SUB   = 2'b10,
    CMD_CLEAR = 2'b11
  } prod_cmd_e;

  // sub-word k at bits [16k+15:16k]
  localparam logic [WORDS_W-1:0] CLEAR_WORDS = {16'h0010, 16'h00ff, 16'hfff0, 16'h0000};
endpackage

// File: rtl/prod_mul.sv
module prod_mul #(
  parameter int unsigned OP_W         = 16,
  parameter int unsigned ACC_W        = 40,
  parameter bit          UNSIGNED_MUL = 1'b0
) (
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic             shift_off_i,
  output logic [ACC_W-1:0] term_o
);
  localparam int unsigned RAW_W = 2 * OP_W;
  localparam int unsigned EXT_W = ACC_W - RAW_W;

  logic [RAW_W-1:0] raw;
  logic [ACC_W-1:0] ext;

  generate
    if (UNSIGNED_MUL) begin : g_unsigned
      always_comb begin
        raw = op_a_i * op_b_i;
        ext = {{EXT_W{1'b0}}, raw};
      end
    end else begin : g_signed
      logic signed [RAW_W-1:0] sraw;
      always_comb begin
        sraw = $signed(op_a_i) * $signed(op_b_i);
        raw  = sraw;
        ext  = {{EXT_W{raw[RAW_W-1]}}, raw};
      end
    end
  endgenerate

  // fractional alignment unless disabled
  assign term_o = shift_off_i ? ext : {ext[ACC_W-2:0], 1'b0};
endmodule

// File: rtl/prod_compose.sv
module prod_compose
  import frac_prod_pkg::*;
#(
  parameter int unsigned ACC_W = 40
) (
  input  logic [WORDS_W-1:0] words_i,
  output logic [ACC_W-1:0]   value_o
);
  logic [ACC_W-1:0] w0, w1, w2, w3;

  always_comb begin
    w0 = ACC_W'(words_i[0*WORD_W +: WORD_W]);
    w1 = ACC_W'(words_i[1*WORD_W +: WORD_W]);
    w2 = ACC_W'(words_i[2*WORD_W +: WORD_W]);
    w3 = ACC_W'(words_i[3*WORD_W +: WORD_W]);
    // two middle words overlap at weight 2^16
    value_o = w0 + (w1 << WORD_W) + (w3 << WORD_W) + (w2 << (2 * WORD_W));
  end
endmodule

// File: rtl/prod_split.sv
module prod_split
  import frac_prod_pkg::*;
#(
  parameter int unsigned ACC_W = 40
) (
  input  logic [ACC_W-1:0]   value_i,
  output logic [WORDS_W-1:0] words_o
);
  localparam int unsigned HI_W  = ACC_W - 2 * WORD_W;
  localparam int unsigned PAD_W = WORD_W - HI_W;

  logic [HI_W-1:0] hi;

  assign hi = value_i[ACC_W-1 -: HI_W];
  assign words_o = {{WORD_W{1'b0}},
                    {{PAD_W{hi[HI_W-1]}}, hi},
                    value_i[WORD_W +: WORD_W],
                    value_i[0 +: WORD_W]};
endmodule

// File: rtl/prod_accum.sv
module prod_accum
  import frac_prod_pkg::*;
#(
  parameter int unsigned ACC_W = 40
) (
  input  prod_cmd_e        cmd_i,
  input  logic [ACC_W-1:0] old_i,
  input  logic [ACC_W-1:0] term_i,
  output logic [ACC_W-1:0] next_o
);
  always_comb begin
    unique case (cmd_i)
      CMD_ADD: next_o = old_i + term_i;
      CMD_SUB: next_o = old_i - term_i;
      default: next_o = term_i;
    endcase
  end
endmodule

// File: rtl/frac_prod_unit.sv
module frac_prod_unit
  import frac_prod_pkg::*;
#(
  parameter int unsigned OP_W         = 16,
  parameter int unsigned ACC_W        = 40,
  parameter bit          UNSIGNED_MUL = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           cmd_i,
  input  logic                 shift_off_i,
  input  logic [OP_W-1:0]      op_a_i,
  input  logic [OP_W-1:0]      op_b_i,
  output logic                 valid_o,
  output logic [ACC_W-1:0]     prod_o,
  output logic [WORDS_W-1:0]   prod_words_o
);
  prod_cmd_e          cmd;
  logic [ACC_W-1:0]   term, old_val, next_val;
  logic [WORDS_W-1:0] words_q, next_words;
  logic               valid_q;

  assign cmd = prod_cmd_e'(cmd_i);

  prod_mul #(.OP_W(OP_W), .ACC_W(ACC_W), .UNSIGNED_MUL(UNSIGNED_MUL)) u_mul (
    .op_a_i      (op_a_i),
    .op_b_i      (op_b_i),
    .shift_off_i (shift_off_i),
    .term_o      (term)
  );

  prod_compose #(.ACC_W(ACC_W)) u_compose (
    .words_i (words_q),
    .value_o (old_val)
  );

  prod_accum #(.ACC_W(ACC_W)) u_accum (
    .cmd_i  (cmd),
    .old_i  (old_val),
    .term_i (term),
    .next_o (next_val)
  );

  prod_split #(.ACC_W(ACC_W)) u_split (
    .value_i (next_val),
    .words_o (next_words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= CLEAR_WORDS;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) words_q <= (cmd == CMD_CLEAR) ? CLEAR_WORDS : next_words;
    end
  end

  assign valid_o      = valid_q;
  assign prod_words_o = words_q;
  assign prod_o       = old_val;

  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o) else $error("valid missing"); // R8
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o) else $error("spurious valid"); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(prod_words_o)) else $error("register moved"); // R9
  AST_CLEAR_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cmd_i == 2'b11) |=> (prod_words_o == CLEAR_WORDS && prod_o == '0)) else $error("clear"); // R5
  AST_TOP_WORD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cmd_i != 2'b11) |=> prod_words_o[3*WORD_W +: WORD_W] == '0) else $error("w3"); // R7
endmodule

// File: tb/frac_prod_unit_test.sv
module frac_prod_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic        shift_off = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        valid;
  logic [39:0] prod;
  logic [63:0] words;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [39:0] exp_val;
  logic [63:0] exp_words;

  localparam logic [63:0] CLR_W = {16'h0010, 16'h00ff, 16'hfff0, 16'h0000};

  always #4 clk = ~clk;

  frac_prod_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd),
    .shift_off_i(shift_off), .op_a_i(op_a), .op_b_i(op_b),
    .valid_o(valid), .prod_o(prod), .prod_words_o(words)
  );

  function automatic logic [39:0] mdl_term(logic [15:0] a, logic [15:0] b, bit m);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    if (!m) p = p * 2;
    return p[39:0];
  endfunction

  function automatic logic [63:0] mdl_words(logic [39:0] v);
    return {16'h0000, {8{v[39]}}, v[39:32], v[31:16], v[15:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [1:0] c, logic [15:0] a, logic [15:0] b, bit m, string req);
    logic [39:0] t;
    @(negedge clk);
    start = 1'b1; cmd = c; op_a = a; op_b = b; shift_off = m;
    t = mdl_term(a, b, m);
    case (c)
      2'b00: exp_val = t;
      2'b01: exp_val = exp_val + t;
      2'b10: exp_val = exp_val - t;
      default: exp_val = 40'h0;
    endcase
    exp_words = (c == 2'b11) ? CLR_W : mdl_words(exp_val);
    @(negedge clk);
    start = 1'b0;
    chk(valid == 1'b1, {req, " valid R8"}, 64'(valid), 64'd1);
    chk(prod == exp_val, {req, " value"}, 64'(prod), 64'(exp_val));
    chk(words == exp_words, {req, " words R7"}, words, exp_words);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd = 2'($urandom); op_a = 16'($urandom); op_b = 16'($urandom);
      shift_off = 1'($urandom);
      @(negedge clk);
      chk(valid == 1'b0, "R8 no valid when idle", 64'(valid), 64'd0);
      chk(words == exp_words, "R9 hold when idle", words, exp_words);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R10 reset valid", 64'(valid), 64'd0);
    chk(words == CLR_W, "R10 reset words", words, CLR_W);
    chk(prod == 40'h0, "R6 cleared reads zero", 64'(prod), 64'd0);
    rst_n = 1'b1;
    exp_val = 40'h0; exp_words = CLR_W;

    do_op(2'b01, 16'h0003, 16'h0005, 1'b0, "R3 R6 add after reset");
    do_op(2'b00, 16'h8000, 16'h8000, 1'b0, "R11 R1 min squared");
    chk(prod == 40'h0080000000, "R11 min squared literal", 64'(prod), 64'h0080000000);
    do_op(2'b00, 16'h8000, 16'h8000, 1'b1, "R2 unshifted");
    chk(prod == 40'h0040000000, "R2 literal", 64'(prod), 64'h0040000000);
    do_op(2'b00, 16'hffff, 16'h0001, 1'b0, "R11 minus one");
    chk(prod == 40'hfffffffffe, "R11 minus one literal", 64'(prod), 64'hfffffffffe);
    do_op(2'b10, 16'h1234, 16'h0100, 1'b1, "R4 subtract unshifted");
    do_op(2'b11, 16'h7fff, 16'h7fff, 1'b0, "R5 clear ignores operands");
    do_op(2'b10, 16'h0002, 16'h0003, 1'b0, "R4 R6 subtract after clear");
    do_op(2'b00, 16'h7fff, 16'h7fff, 1'b0, "R1 max squared");
    idle(4);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] c;
      c = 2'($urandom);
      if (c == 2'b11 && ($urandom % 4) != 0) c = 2'b01;
      do_op(c, 16'($urandom), 16'($urandom), 1'($urandom), "R3 R4 random mix");
      if (($urandom % 8) == 0) idle(1);
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(words == CLR_W, "R10 reset mid-run", words, CLR_W);
    chk(valid == 1'b0, "R10 reset valid mid-run", 64'(valid), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule